// File: doc/BRIEF.md
# Codec Register Access Sequencer

This block runs single register reads and writes to an audio codec across a serial audio link that carries a command address slot, a command data slot and a returned status data slot. A host presents a 7-bit register index, a 16-bit value and a direction for one cycle. The block places the index in the address slot and the value in the data slot, and pulses the link control strobes for one cycle. It then waits a fixed number of clock cycles instead of polling, because the link only reports fresh status when the returned value differs from the previous one.

When the wait has run out, a read returns the most recent status value captured during the window, or all-ones if none arrived. A separate flag marks a read whose result differs from the previous read result. Each cold reset and each warm-reset pulse queues one internal read of register 0. The block discards the result of that read, but it does update the comparison baseline. A command that arrives while the block is busy is refused with an error pulse.

Top module: `ac97_regctl`

## Requirements
- R1: While reset is held, busy is 1 (a dummy read is pending), and done, changed, cmd_err, link_ctl and rdata are all 0.
- R2: On launch, link_addr holds {read flag, index[6:0], twelve zero bits}, so the index sits at bit 12 and the read flag at bit 19. For a write, link_data holds the value shifted left by 4. For a read it holds 0. A read index above 0x7F is masked to its low 7 bits.
- R3: In the cycle after a command is accepted, link_ctl pulses for exactly one cycle. Its bits are: bit0 link enable, bit1 frame valid, bit2 read strobe, bit3 write strobe. Bit0 and bit1 are always set together with the strobe, so a read gives 0x7 and a write gives 0xB.
- R4: busy goes high in the cycle after acceptance and stays high for exactly turn_cycles+1 cycles. done pulses for one cycle in the first cycle in which busy is low again.
- R5: A write whose cmd_index is above 0x7F, issued while the block is idle, is dropped: no busy, no link_ctl pulse, no done.
- R6: A read returns bits [19:4] of the last stat_data that had stat_valid high in any busy cycle of the window except the last.
- R7: A read during which no status was captured returns 0xFFFF.
- R8: changed pulses together with done for a read whose result differs from the previous read result, and is 0 otherwise.
- R9: cmd_valid while busy gives a one-cycle cmd_err pulse in the next cycle. The refused command does not alter the transfer in progress, including its slots, its length and its result.
- R10: After reset is released, and after each warm_kick pulse, a read of register 0 runs (link_ctl 0x7, link_addr 0x80000) for turn_cycles+1 busy cycles. It gives no done and leaves rdata unchanged, but its result becomes the baseline for R8.
- R11: A completed write pulses done with changed at 0 and leaves rdata unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset (cold reset) |
| cmd_valid | input | 1 | One-cycle command request |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_index | input | 8 | Register index; bit 7 marks an out-of-range index |
| cmd_wdata | input | 16 | Write value |
| turn_cycles | input | WAIT_W | Turnaround wait in cycles (window is this value + 1) |
| warm_kick | input | 1 | Pulse after a warm reset; queues a dummy read |
| stat_valid | input | 1 | Returned status slot valid |
| stat_data | input | 20 | Returned status slot; value in bits [19:4] |
| link_addr | output | 20 | Command address slot |
| link_data | output | 20 | Command data slot |
| link_ctl | output | 4 | Link control strobes: enable, frame valid, read, write |
| busy | output | 1 | Transfer active or dummy read pending |
| done | output | 1 | Host transfer finished |
| rdata | output | 16 | Last host read result |
| changed | output | 1 | Read result differs from the previous read |
| cmd_err | output | 1 | Command refused because busy |

## Verification
The bench builds the block with the default WAIT_W of 16 and drives turn_cycles with small values between 0 and 12. This brings into reach both the degenerate single-cycle window, where no status can be captured and a read must return all-ones, and longer windows that carry status, refused commands and repeated values. Random transfers draw indices from the full 8-bit range, so dropped writes and masked reads occur. Directed cases cover the dummy reads after cold and warm reset and the baseline they leave for change detection.

// File: rtl/ac97_regctl.sv
module ac97_regctl #(
  parameter int WAIT_W = 16,
  parameter int IDX_W  = 7,
  parameter int VAL_W  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cmd_valid,
  input  logic                 cmd_write,
  input  logic [IDX_W:0]       cmd_index,
  input  logic [VAL_W-1:0]     cmd_wdata,
  input  logic [WAIT_W-1:0]    turn_cycles,
  input  logic                 warm_kick,
  input  logic                 stat_valid,
  input  logic [VAL_W+3:0]     stat_data,
  output logic [IDX_W+12:0]    link_addr,
  output logic [VAL_W+3:0]     link_data,
  output logic [3:0]           link_ctl,
  output logic                 busy,
  output logic                 done,
  output logic [VAL_W-1:0]     rdata,
  output logic                 changed,
  output logic                 cmd_err
);
  localparam int SLOT_W = VAL_W + 4;
  localparam int ADDR_W = IDX_W + 13;
  localparam logic [3:0] CTL_RD = 4'b0111;
  localparam logic [3:0] CTL_WR = 4'b1011;

  logic              active, pend, is_rd, is_dummy, got;
  logic [WAIT_W-1:0] cnt;
  logic [VAL_W-1:0]  cap, prev;

  assign busy = active | pend;

  wire              launch_dummy = pend & ~active;
  wire              accept = cmd_valid & ~busy & ~(cmd_write & cmd_index[IDX_W]);
  wire [VAL_W-1:0]  res = got ? cap : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      pend      <= 1'b1;
      is_rd     <= 1'b0;
      is_dummy  <= 1'b0;
      got       <= 1'b0;
      cnt       <= '0;
      cap       <= '0;
      prev      <= '0;
      rdata     <= '0;
      done      <= 1'b0;
      changed   <= 1'b0;
      cmd_err   <= 1'b0;
      link_ctl  <= '0;
      link_addr <= '0;
      link_data <= '0;
    end else begin
      done     <= 1'b0;
      changed  <= 1'b0;
      link_ctl <= '0;
      cmd_err  <= cmd_valid & busy;
      if (launch_dummy) begin
        active    <= 1'b1;
        pend      <= 1'b0;
        is_rd     <= 1'b1;
        is_dummy  <= 1'b1;
        got       <= 1'b0;
        cnt       <= turn_cycles;
        link_ctl  <= CTL_RD;
        link_addr <= {1'b1, {(ADDR_W-1){1'b0}}};
        link_data <= '0;
      end else if (accept) begin
        active    <= 1'b1;
        is_rd     <= ~cmd_write;
        is_dummy  <= 1'b0;
        got       <= 1'b0;
        cnt       <= turn_cycles;
        link_ctl  <= cmd_write ? CTL_WR : CTL_RD;
        link_addr <= {~cmd_write, cmd_index[IDX_W-1:0], 12'b0};
        link_data <= cmd_write ? {cmd_wdata, 4'b0} : '0;
      end else if (active) begin
        if (cnt == '0) begin
          active <= 1'b0;
          done   <= ~is_dummy;
          if (is_rd) begin
            prev <= res;
            if (!is_dummy) begin
              rdata   <= res;
              changed <= (res != prev);
            end
          end
        end else begin
          cnt <= cnt - 1'b1;
          if (is_rd && stat_valid) begin
            cap <= stat_data[SLOT_W-1:4];
            got <= 1'b1;
          end
        end
      end
      if (warm_kick) pend <= 1'b1;
    end
  end
endmodule

// File: rtl/ac97_regctl_chk.sv
module ac97_regctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        cmd_valid,
  input logic        busy,
  input logic        done,
  input logic        changed,
  input logic        cmd_err,
  input logic [3:0]  link_ctl,
  input logic [19:0] link_addr
);
  // R4
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R4
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy);
  // R3
  ctl_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) (link_ctl != 4'b0) |-> busy);
  // R3
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(link_ctl[3:2]));
  // R3
  strobe_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (link_ctl[3] || link_ctl[2]) |-> (link_ctl[1:0] == 2'b11));
  // R3
  ctl_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) (link_ctl != 4'b0) |=> (link_ctl == 4'b0));
  // R8
  changed_done_chk: assert property (@(posedge clk) disable iff (!rst_n) changed |-> done);
  // R9
  refuse_err_chk: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid && busy) |=> cmd_err);
  // R9
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && link_ctl == 4'b0 && $past(busy) && $past(rst_n)) |-> $stable(link_addr));
endmodule

bind ac97_regctl ac97_regctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
  .changed(changed), .cmd_err(cmd_err), .link_ctl(link_ctl), .link_addr(link_addr)
);

// File: tb/ac97_regctl_tb.sv
module ac97_regctl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_write = 1'b0, warm_kick = 1'b0, stat_valid = 1'b0;
  logic [7:0]  cmd_index = '0;
  logic [15:0] cmd_wdata = '0;
  logic [15:0] turn_cycles = 16'd3;
  logic [19:0] stat_data = '0;
  logic [19:0] link_addr, link_data;
  logic [3:0]  link_ctl;
  logic        busy, done, changed, cmd_err;
  logic [15:0] rdata;

  int checks = 0, fails = 0;
  logic [15:0] prev_m = 16'h0, rdata_m = 16'h0;

  always #4 clk = ~clk;

  ac97_regctl u_dut (.*);

  task automatic check(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [19:0] exp_addr(bit wr, logic [7:0] idx);
    return {~wr, idx[6:0], 12'b0};
  endfunction

  function automatic logic [19:0] exp_data(bit wr, logic [15:0] v);
    return wr ? {v, 4'b0} : 20'h0;
  endfunction

  task automatic watch_dummy(int n, bit give, logic [15:0] sv);
    int cnt = 1;
    @(negedge clk);
    check("R10 dummy ctl", link_ctl, 4'h7);
    check("R10 dummy addr", link_addr, 20'h80000);
    check("R10 dummy busy", busy, 1);
    if (give && n >= 1) begin stat_valid = 1'b1; stat_data = {sv, 4'h5}; end
    forever begin
      @(negedge clk);
      stat_valid = 1'b0;
      if (done) check("R10 no done", done, 0);
      if (!busy) break;
      cnt++;
    end
    check("R10 dummy length", cnt, n + 1);
    check("R10 rdata kept", rdata, rdata_m);
    prev_m = (give && n >= 1) ? sv : 16'hFFFF;
  endtask

  task automatic txn(bit wr, logic [7:0] idx, logic [15:0] wd, int n, bit give, logic [15:0] sv, bit poke);
    int cnt = 1;
    logic [15:0] res;
    turn_cycles = 16'(n);
    cmd_valid = 1'b1; cmd_write = wr; cmd_index = idx; cmd_wdata = wd;
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wr && idx[7]) begin
      check("R5 drop busy", busy, 0);
      check("R5 drop ctl", link_ctl, 0);
      @(negedge clk);
      check("R5 drop done", done, 0);
      return;
    end
    check("R4 busy start", busy, 1);
    check("R3 ctl", link_ctl, wr ? 4'hB : 4'h7);
    check("R2 addr", link_addr, exp_addr(wr, idx));
    check("R2 data", link_data, exp_data(wr, wd));
    if (give && n >= 1 && !wr) begin stat_valid = 1'b1; stat_data = {sv, 4'h9}; end
    if (poke && n >= 1) begin
      cmd_valid = 1'b1; cmd_write = 1'b1; cmd_index = 8'h11; cmd_wdata = 16'hDEAD;
    end
    forever begin
      @(negedge clk);
      stat_valid = 1'b0;
      if (poke && cnt == 1 && n >= 1) begin
        check("R9 err pulse", cmd_err, 1);
        check("R9 addr kept", link_addr, exp_addr(wr, idx));
        cmd_valid = 1'b0;
      end
      if (!busy) break;
      check("R3 ctl quiet", link_ctl, 0);
      cnt++;
    end
    check("R4 busy length", cnt, n + 1);
    check("R4 done", done, 1);
    if (wr) begin
      check("R11 changed", changed, 0);
      check("R11 rdata kept", rdata, rdata_m);
    end else begin
      res = (give && n >= 1) ? sv : 16'hFFFF;
      check(give && n >= 1 ? "R6 rdata" : "R7 rdata", rdata, res);
      check("R8 changed", changed, int'(res != prev_m));
      prev_m = res; rdata_m = res;
    end
    @(negedge clk);
    check("R4 done single", done, 0);
    check("R9 err single", cmd_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1 busy", busy, 1);
    check("R1 done", done, 0);
    check("R1 changed", changed, 0);
    check("R1 err", cmd_err, 0);
    check("R1 ctl", link_ctl, 0);
    check("R1 rdata", rdata, 0);
    turn_cycles = 16'd3;
    rst_n = 1'b1;
    watch_dummy(3, 1, 16'h1234);
    // R8 baseline from dummy: same value gives no change
    txn(0, 8'h02, 16'h0, 4, 1, 16'h1234, 0);
    txn(0, 8'h02, 16'h0, 4, 1, 16'h5678, 0);
    txn(1, 8'h26, 16'hABCD, 2, 0, 16'h0, 0);
    txn(1, 8'hA6, 16'hABCD, 2, 0, 16'h0, 0);
    txn(0, 8'hFC, 16'h0, 0, 0, 16'h0, 0);
    txn(0, 8'h7C, 16'h0, 0, 0, 16'h0, 0);
    txn(0, 8'h10, 16'h0, 5, 1, 16'h0F0F, 1);
    // R10 warm path
    turn_cycles = 16'd2;
    warm_kick = 1'b1;
    @(negedge clk);
    warm_kick = 1'b0;
    check("R10 pending busy", busy, 1);
    watch_dummy(2, 0, 16'h0);
    txn(0, 8'h00, 16'h0, 3, 0, 16'h0, 0);
    for (int i = 0; i < 60; i++) begin
      bit wr = 1'($urandom_range(0, 1));
      logic [7:0] idx = 8'($urandom_range(0, 255));
      logic [15:0] wd = 16'($urandom);
      int n = $urandom_range(0, 12);
      bit give = ($urandom_range(0, 9) < 7);
      logic [15:0] sv = 16'($urandom_range(0, 3));
      bit poke = ($urandom_range(0, 4) == 0);
      txn(wr, idx, wd, n, give, sv, poke);
    end
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule